// File: doc/BRIEF.md
# Calorimeter Channel Digital Conditioner

This block conditions the sample stream of one calorimeter half-channel. An unsigned 10-bit digitised sample enters once per bunch period, alongside a valid strobe. A short pipeline processes each accepted sample in a fixed order. First it removes the channel baseline. Next it scales the result by a channel gain. Last it removes pile-up, which is the tail that the previous pulse leaves in the current period. The corrected value is never negative.

Two results leave the block. The first is an 8-bit floating-point code for the physics data path: small values are carried linearly, and large values as an exponent with five mantissa bits. The second is a one-bit trigger flag that is set when the corrected value is above a programmable level. The four per-channel settings (baseline, gain, pile-up fraction, trigger level) are loaded through a small register write port.

The block holds no state machine. The only history it keeps is the last corrected value, which the pile-up stage needs.

Top module: `calo_conditioner`

## Requirements
- R1: A sample presented with `in_valid` high leads to `out_valid` high exactly 3 clock cycles later, carrying that sample's result. Each cycle with `in_valid` low gives `out_valid` low 3 cycles later. Results come out in arrival order.
- R2: Baseline removal gives `in_sample - baseline` when the sample is above the baseline, and 0 otherwise. It never wraps.
- R3: The gain is unsigned with 8 fractional bits, so 256 means unity. The scaled value is `(baseline_removed * gain) >> 8`, truncated, and is 12 bits wide.
- R4: Pile-up removal subtracts `(history * fraction) >> 8` from the scaled value and clamps the result at 0. The fraction is 8 bits, all of them fractional. `history` is the corrected value of the most recent valid sample, and is 0 after reset. Cycles with `in_valid` low, and the sample bits presented in those cycles, leave `history` unchanged.
- R5: Output code. A corrected value `v` below 32 gives `out_code = v`. Otherwise, let `p` be the bit index of the leading one of `v` (5 to 11). Then `out_code[7:5] = p - 4` and `out_code[4:0] = v[p-1:p-5]`.
- R6: `out_trig` is 1 when the corrected value is strictly greater than the trigger level, and 0 when it is equal or less.
- R7: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_addr`. The registers are: 0 baseline (10 bits), 1 gain (10 bits), 2 pile-up fraction (8 bits), 3 trigger level (12 bits). Each field is aligned to bit 0. After reset the values are baseline 0, gain 256, fraction 0 and level 4095.
- R8: During reset and right after it, `out_valid`, `out_code` and `out_trig` are 0. While `out_valid` is low, `out_code` and `out_trig` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 10 | Unsigned digitised sample |
| cfg_we | input | 1 | Settings write enable |
| cfg_addr | input | 2 | Settings register select |
| cfg_wdata | input | 12 | Settings write data, aligned to bit 0 |
| out_valid | output | 1 | Result strobe, 3 cycles after `in_valid` |
| out_code | output | 8 | Floating-point physics code |
| out_trig | output | 1 | Trigger flag |

## Verification
The hardest case to reach from the ports is the pile-up history. It has to be large and then meet a large fraction before the clamp at zero and the carry of history across idle cycles can be seen. The bench forces this with directed runs. A large pulse is followed by a fraction write and then a smaller sample, and a zero sample is sent straight after a large one. Idle cycles carry random values on `in_sample`. Several random blocks then draw fresh settings, including gains near full scale, and send gapped streams of samples. These streams drive the corrected value through every exponent and over both sides of the trigger level.

// File: rtl/ccond_pkg.sv
package ccond_pkg;
    localparam int SAMPLE_W = 10;
    localparam int COEF_W   = 10;
    localparam int FRAC_W   = 8;
    localparam int PILE_W   = 8;
    localparam int MANT_W   = 5;
    localparam int EXP_W    = 3;
    localparam int ADDR_W   = 2;
    localparam int VAL_W    = SAMPLE_W + COEF_W - FRAC_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_BASE  = 2'd0,
        REG_GAIN  = 2'd1,
        REG_PILE  = 2'd2,
        REG_LEVEL = 2'd3
    } cfg_reg_e;
endpackage

// File: rtl/ccond_cfg_regs.sv
module ccond_cfg_regs
    import ccond_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int CW = COEF_W,
    parameter int PW = PILE_W,
    parameter int VW = VAL_W,
    parameter int FW = FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VW-1:0]     wdata,
    output logic [SW-1:0]     base_q,
    output logic [CW-1:0]     gain_q,
    output logic [PW-1:0]     pile_q,
    output logic [VW-1:0]     level_q
);
    localparam logic [CW-1:0] GAIN_UNITY = CW'(1 << FW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            gain_q  <= GAIN_UNITY;
            pile_q  <= '0;
            level_q <= '1;
        end else if (we) begin
            unique case (cfg_reg_e'(addr))
                REG_BASE:  base_q  <= wdata[SW-1:0];
                REG_GAIN:  gain_q  <= wdata[CW-1:0];
                REG_PILE:  pile_q  <= wdata[PW-1:0];
                REG_LEVEL: level_q <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ccond_base_gain.sv
module ccond_base_gain
    import ccond_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int CW = COEF_W,
    parameter int FW = FRAC_W,
    parameter int VW = VAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_sample,
    input  logic [SW-1:0] base_q,
    input  logic [CW-1:0] gain_q,
    output logic          s2_valid,
    output logic [VW-1:0] s2_value
);
    localparam int PROD_W = SW + CW;

    logic          s1_valid;
    logic [SW-1:0] s1_level;
    logic [SW-1:0] base_rm;
    logic [PROD_W-1:0] prod;

    // stage 1: baseline removal clamped at zero
    always_comb begin
        base_rm = (in_sample > base_q) ? (in_sample - base_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_level <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_level <= base_rm;
        end
    end

    // stage 2: fixed-point gain, truncated
    always_comb begin
        prod = PROD_W'(s1_level) * PROD_W'(gain_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_value <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) s2_value <= VW'(prod >> FW);
        end
    end
endmodule

// File: rtl/ccond_pileup_code.sv
module ccond_pileup_code
    import ccond_pkg::*;
#(
    parameter int VW = VAL_W,
    parameter int PW = PILE_W,
    parameter int MW = MANT_W,
    parameter int EW = EXP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s2_valid,
    input  logic [VW-1:0]  s2_value,
    input  logic [PW-1:0]  pile_q,
    input  logic [VW-1:0]  level_q,
    output logic           out_valid,
    output logic [EW+MW-1:0] out_code,
    output logic           out_trig
);
    localparam int SUBP_W = VW + PW;

    logic [VW-1:0]     history;
    logic [SUBP_W-1:0] sub_prod;
    logic [VW-1:0]     tail;
    logic [VW-1:0]     corr;
    logic [EW-1:0]     exp_c;
    logic [MW-1:0]     mant_c;

    always_comb begin
        sub_prod = SUBP_W'(history) * SUBP_W'(pile_q);
        tail     = VW'(sub_prod >> PW);
        corr     = (s2_value > tail) ? (s2_value - tail) : '0;
    end

    // float coding: leading one above the mantissa field sets the exponent
    always_comb begin
        exp_c  = '0;
        mant_c = corr[MW-1:0];
        for (int i = MW; i < VW; i++) begin
            if (corr[i]) begin
                exp_c  = EW'(i - MW + 1);
                mant_c = MW'(corr >> (i - MW));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
            out_trig  <= 1'b0;
            history   <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                history  <= corr;
                out_code <= {exp_c, mant_c};
                out_trig <= (corr > level_q);
            end
        end
    end
endmodule

// File: rtl/calo_conditioner.sv
module calo_conditioner
    import ccond_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [VAL_W-1:0]        cfg_wdata,
    output logic                    out_valid,
    output logic [EXP_W+MANT_W-1:0] out_code,
    output logic                    out_trig
);
    logic [SAMPLE_W-1:0] base_q;
    logic [COEF_W-1:0]   gain_q;
    logic [PILE_W-1:0]   pile_q;
    logic [VAL_W-1:0]    level_q;
    logic                s2_valid;
    logic [VAL_W-1:0]    s2_value;

    ccond_cfg_regs cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .base_q  (base_q),
        .gain_q  (gain_q),
        .pile_q  (pile_q),
        .level_q (level_q)
    );

    ccond_base_gain front_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .base_q    (base_q),
        .gain_q    (gain_q),
        .s2_valid  (s2_valid),
        .s2_value  (s2_value)
    );

    ccond_pileup_code back_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .s2_valid  (s2_valid),
        .s2_value  (s2_value),
        .pile_q    (pile_q),
        .level_q   (level_q),
        .out_valid (out_valid),
        .out_code  (out_code),
        .out_trig  (out_trig)
    );
endmodule

// File: rtl/calo_conditioner_chk.sv
module calo_conditioner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [9:0] in_sample,
    input logic       out_valid,
    input logic [7:0] out_code,
    input logic       out_trig
);
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    a_r2_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sample == 10'd0) |-> ##3 (out_code == 8'd0 && !out_trig));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_code) && $stable(out_trig)));
endmodule

bind calo_conditioner calo_conditioner_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_trig  (out_trig)
);

// File: tb/calo_conditioner_tb_top.sv
`timescale 1ns/1ps
module calo_conditioner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_sample = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic       out_valid;
    logic [7:0] out_code;
    logic       out_trig;

    always #10 clk = ~clk;

    calo_conditioner dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_code(out_code), .out_trig(out_trig)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference settings and history
    int m_base = 0, m_gain = 256, m_pile = 0, m_level = 4095, m_hist = 0;
    int exp_code [0:4095];
    int exp_trig [0:4095];
    string exp_tag [0:4095];
    int wr = 0, rd = 0;
    bit vh0 = 0, vh1 = 0, vh2 = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int enc(input int v);
        int p;
        if (v < 32) return v;
        p = 5;
        for (int b = 5; b < 12; b++) if ((v >> b) & 1) p = b;
        return ((p - 4) << 5) | ((v >> (p - 5)) & 31);
    endfunction

    task automatic model(input int s, input string tag);
        int lvl, g, tl, c;
        lvl = (s > m_base) ? s - m_base : 0;
        g   = (lvl * m_gain) >> 8;
        tl  = (m_hist * m_pile) >> 8;
        c   = (g > tl) ? g - tl : 0;
        m_hist = c;
        exp_code[wr % 4096] = enc(c);
        exp_trig[wr % 4096] = (c > m_level) ? 1 : 0;
        exp_tag[wr % 4096]  = tag;
        wr++;
    endtask

    task automatic observe();
        check(out_valid == vh2, "R1 out_valid timing", int'(out_valid), int'(vh2));
        if (out_valid) begin
            if (rd < wr) begin
                check(int'(out_code) == exp_code[rd % 4096],
                      {"R5 code ", exp_tag[rd % 4096]}, int'(out_code), exp_code[rd % 4096]);
                check(int'(out_trig) == exp_trig[rd % 4096],
                      {"R6 trig ", exp_tag[rd % 4096]}, int'(out_trig), exp_trig[rd % 4096]);
                rd++;
            end else begin
                check(1'b0, "R1 unexpected result", rd, wr);
            end
        end
    endtask

    task automatic tick(input bit v, input int s, input bit we, input int a, input int d,
                        input string tag);
        @(negedge clk);
        observe();
        in_valid  = v;
        in_sample = 10'(s);
        cfg_we    = we;
        cfg_addr  = 2'(a);
        cfg_wdata = 12'(d);
        vh2 = vh1; vh1 = vh0; vh0 = v;
        if (v) model(s, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(0, int'($urandom_range(1023)), 0, 0, 0, "");
    endtask

    // R7: drain the pipe, then write one register
    task automatic cfg_write(input int a, input int d);
        idle(3);
        tick(0, 0, 1, a, d, "");
        case (a)
            0: m_base  = d & 1023;
            1: m_gain  = d & 1023;
            2: m_pile  = d & 255;
            default: m_level = d & 4095;
        endcase
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
        check(out_code == 8'd0, "R8 reset code", int'(out_code), 0);
        check(out_trig == 1'b0, "R8 reset trig", int'(out_trig), 0);
        rst_n = 1'b1;

        // R7 defaults, R3 unity gain, R5 linear and exponent boundaries
        tick(1, 1000, 0, 0, 0, "R7 defaults R3 unity");
        tick(1, 31, 0, 0, 0, "R5 linear top");
        tick(1, 32, 0, 0, 0, "R5 first exponent");
        tick(1, 0, 0, 0, 0, "R5 zero");
        idle(2);

        // R2 baseline clamp
        cfg_write(0, 100);
        tick(1, 50, 0, 0, 0, "R2 below baseline");
        tick(1, 100, 0, 0, 0, "R2 at baseline");
        tick(1, 101, 0, 0, 0, "R2 above baseline");

        // R3 full-scale gain reaches top exponent
        cfg_write(0, 0);
        cfg_write(1, 1023);
        tick(1, 1023, 0, 0, 0, "R3 full scale");
        tick(1, 77, 0, 0, 0, "R3 truncation");

        // R6 strict threshold
        cfg_write(1, 256);
        cfg_write(3, 500);
        tick(1, 500, 0, 0, 0, "R6 equal level");
        tick(1, 501, 0, 0, 0, "R6 above level");

        // R4 pile-up with history kept across idle cycles and ignored samples
        cfg_write(2, 64);
        idle(5);
        tick(1, 400, 0, 0, 0, "R4 history after idle");
        cfg_write(2, 255);
        tick(1, 1023, 0, 0, 0, "R4 big pulse");
        tick(1, 0, 0, 0, 0, "R4 clamp zero");
        tick(1, 300, 0, 0, 0, "R4 after clamp");
        tick(1, 200, 0, 0, 0, "R4 tail exceeds");

        // random blocks with fresh settings
        for (int blk = 0; blk < 6; blk++) begin
            cfg_write(0, int'($urandom_range(300)));
            cfg_write(1, (blk == 2) ? 1023 : int'($urandom_range(1023)));
            cfg_write(2, int'($urandom_range(255)));
            cfg_write(3, int'($urandom_range(4095)));
            for (int k = 0; k < 300; k++) begin
                if ($urandom_range(3) != 0)
                    tick(1, int'($urandom_range(1023)), 0, 0, 0, "R1 R4 random");
                else
                    tick(0, int'($urandom_range(1023)), 0, 0, 0, "");
            end
        end
        idle(5);
        check(rd == wr, "R1 all results delivered", rd, wr);
        // R8: outputs hold while idle
        begin
            logic [7:0] c0;
            logic       t0;
            c0 = out_code;
            t0 = out_trig;
            idle(3);
            check(out_code == c0, "R8 hold code", int'(out_code), int'(c0));
            check(out_trig == t0, "R8 hold trig", int'(out_trig), int'(t0));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule